// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches up to 32 already-synchronized GPIO pin levels and turns selected level conditions or transitions into latched interrupt events. Each pin has its own trigger setting, built from three configuration bits (trigger kind, polarity and any-edge). A matching condition sets that pin's bit in a sticky status register. Software clears a status bit by writing a 1 to it.

A per-pin mask gates which pending bits reach the single bank interrupt output. The mask cannot be written directly. Software changes it through two write-only registers, one that unmasks pins and one that masks them. Detection never stops while a pin is masked. An event that arrives during masking waits in the status register and raises the interrupt as soon as the pin is unmasked.

The register port is a simple 32-bit write strobe with a byte address inside the bank's 64-byte window. Reads are combinational.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the mask reads all ones (every pin masked), status reads 0, irq is low, the kind and polarity registers read all ones and the any-edge register reads 0, so every pin starts as a rising-edge trigger.
- R2: Byte offsets within the bank are: mask 0x0C (read only), unmask 0x10 (write only, reads 0), mask-set 0x14 (write only, reads 0), status 0x18, kind 0x1C, polarity 0x20 and any-edge 0x24. Kind, polarity and any-edge read back the value last written. Bit i of every register belongs to pin i.
- R3: With kind bit 0 (level), the status bit sets at every clock edge where the sampled pin is 1 (polarity 1) or 0 (polarity 0). The any-edge bit has no effect in this mode.
- R4: With kind bit 1 and any-edge 0, polarity 1 sets status on a 0-to-1 change and polarity 0 on a 1-to-0 change between consecutive clock samples. The bit sets at the edge where the new level is first sampled.
- R5: With kind bit 1 and any-edge 1, both directions of change set status and the polarity bit is ignored.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it alone. If an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R7: Each 1 written to the unmask register clears that mask bit, and each 1 written to the mask-set register sets it. Zero bits leave the mask unchanged, writing all ones to mask-set masks the whole bank, and writes to the mask offset are ignored.
- R8: irq is high exactly when some status bit is set while its mask bit is 0. Events are still latched while a pin is masked, and a pending event raises irq in the cycle after the pin is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Synchronized pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte offset inside the bank window |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Combinational read data |
| irq | output | 1 | Bank interrupt, level high |

## Verification
The hardest state to reach is a level-mode bit being cleared while its condition still holds. A clearing write that loses to a new event can only be seen one cycle later, and only if the bench knows which residual events the previous pin level left behind. The bench sweeps every combination of the three trigger bits on pins at both ends and in the middle of the bank. For each combination it drives a fixed pin sequence that holds, rises, holds, falls, holds and rises again, and clears status between steps. The expected status word for each step follows from the previous level, the new level and the level left during the clear. Each pass ends by unmasking a pin with an event pending, then masking the whole bank again.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq
);
  localparam logic [AW-1:0] OFS_MASK = AW'(6'h0C);
  localparam logic [AW-1:0] OFS_EN   = AW'(6'h10);
  localparam logic [AW-1:0] OFS_DIS  = AW'(6'h14);
  localparam logic [AW-1:0] OFS_STS  = AW'(6'h18);
  localparam logic [AW-1:0] OFS_KIND = AW'(6'h1C);
  localparam logic [AW-1:0] OFS_POL  = AW'(6'h20);
  localparam logic [AW-1:0] OFS_ANY  = AW'(6'h24);

  logic [NPINS-1:0] mask_q, status_q, kind_q, pol_q, any_q, pin_q;
  logic [NPINS-1:0] rd_bits;

  wire [NPINS-1:0] wbits = reg_wdata[NPINS-1:0];
  wire wr_en   = reg_we && (reg_addr == OFS_EN);
  wire wr_dis  = reg_we && (reg_addr == OFS_DIS);
  wire wr_sts  = reg_we && (reg_addr == OFS_STS);
  wire wr_kind = reg_we && (reg_addr == OFS_KIND);
  wire wr_pol  = reg_we && (reg_addr == OFS_POL);
  wire wr_any  = reg_we && (reg_addr == OFS_ANY);

  wire [NPINS-1:0] rise  = pin_in & ~pin_q;
  wire [NPINS-1:0] fall  = ~pin_in & pin_q;
  wire [NPINS-1:0] edge_hit = (any_q & (rise | fall))
                            | (~any_q & pol_q & rise)
                            | (~any_q & ~pol_q & fall);
  wire [NPINS-1:0] lvl_hit  = (pol_q & pin_in) | (~pol_q & ~pin_in);
  wire [NPINS-1:0] hit      = (kind_q & edge_hit) | (~kind_q & lvl_hit);
  wire [NPINS-1:0] clr      = wr_sts ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= '0;
      mask_q   <= '1;
      status_q <= '0;
      kind_q   <= '1;
      pol_q    <= '1;
      any_q    <= '0;
    end else begin
      pin_q    <= pin_in;
      status_q <= (status_q & ~clr) | hit;
      if (wr_en)   mask_q <= mask_q & ~wbits;
      if (wr_dis)  mask_q <= mask_q | wbits;
      if (wr_kind) kind_q <= wbits;
      if (wr_pol)  pol_q  <= wbits;
      if (wr_any)  any_q  <= wbits;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_MASK: rd_bits = mask_q;
      OFS_STS:  rd_bits = status_q;
      OFS_KIND: rd_bits = kind_q;
      OFS_POL:  rd_bits = pol_q;
      OFS_ANY:  rd_bits = any_q;
      default:  rd_bits = '0;
    endcase
    reg_rdata = '0;
    reg_rdata[NPINS-1:0] = rd_bits;
  end

  assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_bank_checker.sv
module gpio_irq_bank_checker #(
  parameter int NPINS = 32,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic             irq,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] status_q
);
  localparam logic [AW-1:0] A_EN  = AW'(6'h10);
  localparam logic [AW-1:0] A_DIS = AW'(6'h14);
  localparam logic [AW-1:0] A_STS = AW'(6'h18);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> ((&mask_q) && (status_q == '0)));

  assert_unmask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_EN) |=>
      ((mask_q & $past(reg_wdata[NPINS-1:0])) == '0));

  assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DIS) |=>
      ((mask_q & $past(reg_wdata[NPINS-1:0])) == $past(reg_wdata[NPINS-1:0])));

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && (reg_addr == A_EN || reg_addr == A_DIS)) |=> $stable(mask_q));

  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_STS) |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_irq_needs_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != '0));

  assert_all_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);
endmodule

bind gpio_irq_bank gpio_irq_bank_checker #(.NPINS(NPINS), .AW(AW), .DW(DW)) chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .mask_q(mask_q), .status_q(status_q)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
  localparam int N = 32;
  localparam logic [5:0] A_MASK = 6'h0C, A_EN = 6'h10, A_DIS = 6'h14, A_STS = 6'h18,
                         A_KIND = 6'h1C, A_POL = 6'h20, A_ANY = 6'h24;

  logic clk = 0, rst_n = 0, reg_we = 0, irq;
  logic [N-1:0] pin_in = '0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_bank uut (.clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic bit trig(input int m, input bit a, input bit b, input bit residual);
    bit kind = (m < 4);
    bit pol  = m[0];
    bit any  = m[1];
    bit lvl_a = pol ? a : !a;
    bit lvl_b = pol ? b : !b;
    if (!kind) return (residual && lvl_a) || lvl_b;
    if (any) return a != b;
    return pol ? (!a && b) : (a && !b);
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int pins[4] = '{0, 5, 17, 31};
    bit seq[6] = '{0, 1, 1, 0, 0, 1};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(A_MASK, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(A_STS, v);  check("R1 status", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd(A_KIND, v); check("R1 kind", v, 32'hFFFF_FFFF);
    rd(A_POL, v);  check("R1 pol", v, 32'hFFFF_FFFF);
    rd(A_ANY, v);  check("R1 any", v, 0);

    // R2 readback and write-only reads
    wr(A_KIND, 32'h1234_5678); rd(A_KIND, v); check("R2 kind", v, 32'h1234_5678);
    wr(A_POL, 32'hA5A5_0F0F);  rd(A_POL, v);  check("R2 pol", v, 32'hA5A5_0F0F);
    wr(A_ANY, 32'h0000_FFFF);  rd(A_ANY, v);  check("R2 any", v, 32'h0000_FFFF);
    rd(A_EN, v);  check("R2 unmask reads 0", v, 0);
    rd(A_DIS, v); check("R2 mask-set reads 0", v, 0);
    wr(A_KIND, '1); wr(A_POL, '1); wr(A_ANY, '0);
    step(); wr(A_STS, '1);
    rd(A_STS, v); check("R2 status cleared", v, 0);

    // R7 mask control
    wr(A_MASK, 32'h0); rd(A_MASK, v); check("R7 mask write ignored", v, 32'hFFFF_FFFF);
    wr(A_EN, 32'h0000_00F0); rd(A_MASK, v); check("R7 unmask", v, 32'hFFFF_FF0F);
    wr(A_DIS, 32'h0000_0030); rd(A_MASK, v); check("R7 mask-set", v, 32'hFFFF_FF3F);
    wr(A_EN, 32'h0); wr(A_DIS, 32'h0); rd(A_MASK, v); check("R7 zeros", v, 32'hFFFF_FF3F);
    wr(A_DIS, '1); rd(A_MASK, v); check("R7 mask all", v, 32'hFFFF_FFFF);

    // R6 clear vs new event in the same cycle (pin 3 rising)
    pin_in[3] = 1; wr(A_STS, 32'h8);
    rd(A_STS, v); check("R6 set wins", v, 32'h8);
    wr(A_STS, 32'h1); rd(A_STS, v); check("R6 zero bits keep", v, 32'h8);
    wr(A_STS, 32'h8); rd(A_STS, v); check("R6 w1c", v, 0);
    pin_in = '0; step(); wr(A_STS, '1);

    // R3 R4 R5 R8 sweep
    for (int pi = 0; pi < 4; pi++) begin
      for (int m = 0; m < 8; m++) begin
        int p = pins[pi];
        bit prev, exp;
        logic [31:0] bitp = 32'h1 << p;
        pin_in = '0; step();
        wr(A_KIND, (m < 4) ? 32'hFFFF_FFFF : ~bitp);
        wr(A_POL, m[0] ? 32'hFFFF_FFFF : ~bitp);
        wr(A_ANY, m[1] ? bitp : 32'h0);
        wr(A_STS, '1);
        prev = 0; exp = 0;
        for (int s = 0; s < 6; s++) begin
          pin_in[p] = seq[s];
          step();
          exp = trig(m, prev, seq[s], 1'b1);
          rd(A_STS, v);
          check($sformatf("%s pin%0d mode%0d step%0d", (m >= 4) ? "R3" : (m[1] ? "R5" : "R4"), p, m, s),
                v, exp ? bitp : 32'h0);
          check("R8 masked no irq", {31'b0, irq}, 0);
          prev = seq[s];
          if (s != 5) wr(A_STS, '1);
        end
        wr(A_EN, bitp);
        check($sformatf("R8 pending fires pin%0d mode%0d", p, m), {31'b0, irq}, {31'b0, exp});
        wr(A_DIS, '1);
        check("R8 mask all quiet", {31'b0, irq}, 0);
        wr(A_STS, '1);
      end
    end

    pin_in = '0; step();
    wr(A_KIND, '1); wr(A_POL, '1); wr(A_ANY, '0); wr(A_STS, '1);
    wr(A_EN, 32'h4); pin_in[2] = 1; step();
    check("R8 unmasked live event", {31'b0, irq}, 1);
    wr(A_STS, 32'h4);
    check("R8 irq drops after clear", {31'b0, irq}, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule